// File: doc/BRIEF.md
# Interrupt Redirection Controller with MSI

This block collects a set of interrupt request lines and routes each through its own 64-bit routing entry. When a line becomes active and is allowed to signal, the block issues one message-signalled interrupt, a single 32-bit memory write, on a valid/ready write channel. The write's address selects the target core's local interrupt controller, and its data carries the vector.

Software reaches every internal register through a small memory-mapped window. It writes a slot number into a selector register and then reads or writes the selected slot through a data register. A third register takes end-of-interrupt notifications. The slots hold an identification register, a version register and two 32-bit halves for each routing entry. Lines can be edge or level sensitive and active high or active low. A level line is blocked after each delivery until software signals the end of that interrupt with the matching vector. When several lines are pending, they are served one message at a time in round-robin order.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every window register reads 0: the selector at offset 0x00, the data register at offset 0x10 (slot 0) and the end-of-interrupt register at offset 0x40. Every routing entry's low half reads 0x00010000 (masked), and msi_valid is 0.
- R2: A write to offset 0x00 stores slot number wdata[7:0], which reads back at offset 0x00. Slot 0 is the identification register: only bits [31:24] are writable, and the other bits read 0. Slot 1 is the version register and reads {8'h00, NLINE-1, 8'h00, 8'h20}, which is 0x00170020 by default; writes to it are ignored. Every slot not listed here reads 0 and ignores writes.
- R3: Line n's entry sits at slot 0x10+2n (low half) and slot 0x11+2n (high half). The low half holds vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger [15] (1 = level) and mask [16]. The high half holds the extended destination [23:16] and the destination [31:24]. Bits 12 and 14 are read-only, and all other bits read 0.
- R4: Each message has address {12'hFEE, dest, ext_dest, 4'h0} and data {16'h0, trigger, 4'h0, delivery_mode, vector}.
- R5: An edge line sends exactly one message for each inactive-to-active transition. With polarity 1, a low level on the input counts as active.
- R6: A level line that is active while its remote IRR is 0 sends one message. Remote IRR is set when that message is accepted, and no further message is sent while it stays 1.
- R7: A write to offset 0x40 clears remote IRR on every level entry whose vector equals wdata[7:0]. Entries with any other vector keep their remote IRR.
- R8: A masked line never sends a message. An edge that occurs while the line is masked is lost: unmasking the line later, while its input is still active, sends nothing.
- R9: Delivery status reads 1 from the moment a line is pending until its message is accepted, and 0 afterwards.
- R10: Pending lines are served one at a time, starting from the line after the last accepted one and wrapping from NLINE-1 to 0.
- R11: While msi_valid is 1 and msi_ready is 0, msi_valid, msi_addr and msi_data stay unchanged. Acceptance drops msi_valid for at least one cycle.
- R12: A line whose vector lies outside 0x10..0xFE never sends a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINE | Interrupt request lines, synchronous to clk |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| msi_valid | output | 1 | Message write is presented |
| msi_ready | input | 1 | Sink accepts the message this cycle |
| msi_addr | output | 32 | Message write address |
| msi_data | output | 32 | Message write data |

## Verification
The bench holds msi_ready low while several lines fire in the same cycle. This checks that the wrap-around order starts after the last served line, that the held message does not change, and that delivery status stays up until acceptance. A design that restarted from line 0 would deliver the messages out of order, and one that cleared status when it picked a line would read 0 too early. A level line is kept active across end-of-interrupt writes with a wrong vector and then with the right one. If remote IRR were not tracked, the bench would see a flood of messages. If it were cleared on any end-of-interrupt write, an early second message would appear. The bench also covers an edge raised while masked and a line programmed with an out-of-range vector: a design that remembered the edge, or did not check the vector, would emit a message the scoreboard never expected.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic [7:0] edest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dstmode;
    logic [2:0] dmode;
    logic [7:0] vec;
  } rte_cfg_t;

  localparam rte_cfg_t RTE_RESET = '{dest: 8'h00, edest: 8'h00, mask: 1'b1,
                                     trig: 1'b0, pol: 1'b0, dstmode: 1'b0,
                                     dmode: 3'h0, vec: 8'h00};

  function automatic logic vec_ok(input logic [7:0] v);
    return (v >= 8'h10) && (v <= 8'hFE);
  endfunction

  function automatic logic [31:0] msi_addr_of(input rte_cfg_t c);
    return {12'hFEE, c.dest, c.edest, 4'h0};
  endfunction

  function automatic logic [31:0] msi_data_of(input rte_cfg_t c);
    return {16'h0000, c.trig, 4'h0, c.dmode, c.vec};
  endfunction

  function automatic logic [31:0] rte_lo(input rte_cfg_t c, input logic sts,
                                         input logic rirr);
    return {15'h0, c.mask, c.trig, rirr, c.pol, sts, c.dstmode, c.dmode, c.vec};
  endfunction

  function automatic logic [31:0] rte_hi(input rte_cfg_t c);
    return {c.dest, c.edest, 16'h0000};
  endfunction

  function automatic rte_cfg_t lo_write(input rte_cfg_t c, input logic [31:0] w);
    rte_cfg_t r;
    r         = c;
    r.vec     = w[7:0];
    r.dmode   = w[10:8];
    r.dstmode = w[11];
    r.pol     = w[13];
    r.trig    = w[15];
    r.mask    = w[16];
    return r;
  endfunction

  function automatic rte_cfg_t hi_write(input rte_cfg_t c, input logic [31:0] w);
    rte_cfg_t r;
    r       = c;
    r.dest  = w[31:24];
    r.edest = w[23:16];
    return r;
  endfunction

endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int NLINE = 24,
  parameter int AW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NLINE-1:0]  line_sts,
  input  logic [NLINE-1:0]  line_rirr,
  output rte_cfg_t          cfg [NLINE],
  output logic              eoi_valid,
  output logic [7:0]        eoi_vec
);
  localparam logic [AW-1:0] OFS_IDX   = AW'('h00);
  localparam logic [AW-1:0] OFS_WIN   = AW'('h10);
  localparam logic [AW-1:0] OFS_EOI   = AW'('h40);
  localparam int            SLOT_BASE = 16;
  localparam int            SLOT_END  = SLOT_BASE + 2 * NLINE;
  localparam logic [31:0]   VERSION   = {8'h00, 8'(NLINE - 1), 8'h00, 8'h20};

  logic [7:0]  idx_q;
  logic [7:0]  id_q;
  logic [31:0] win_data;

  // Named access events, visible to assertions and waveforms alike.
  logic wr_idx, wr_win, in_table, half;
  logic [7:0] rel, ent;

  assign wr_idx   = reg_valid && reg_write && (reg_addr == OFS_IDX);
  assign wr_win   = reg_valid && reg_write && (reg_addr == OFS_WIN);
  assign in_table = (int'(idx_q) >= SLOT_BASE) && (int'(idx_q) < SLOT_END);
  assign rel      = idx_q - 8'(SLOT_BASE);
  assign ent      = {1'b0, rel[7:1]};
  assign half     = rel[0];

  assign eoi_valid = reg_valid && reg_write && (reg_addr == OFS_EOI);
  assign eoi_vec   = reg_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      id_q  <= 8'h00;
    end else begin
      if (wr_idx) idx_q <= reg_wdata[7:0];
      if (wr_win && idx_q == 8'h00) id_q <= reg_wdata[31:24];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINE; i++) begin
      if (!rst_n) begin
        cfg[i] <= RTE_RESET;
      end else if (wr_win && in_table && ent == 8'(i)) begin
        cfg[i] <= half ? hi_write(cfg[i], reg_wdata) : lo_write(cfg[i], reg_wdata);
      end
    end
  end

  always_comb begin
    win_data = 32'h0;
    if (idx_q == 8'h00) begin
      win_data = {id_q, 24'h0};
    end else if (idx_q == 8'h01) begin
      win_data = VERSION;
    end else if (in_table) begin
      for (int i = 0; i < NLINE; i++) begin
        if (ent == 8'(i)) begin
          win_data = half ? rte_hi(cfg[i]) : rte_lo(cfg[i], line_sts[i], line_rirr[i]);
        end
      end
    end
  end

  always_comb begin
    if (reg_addr == OFS_IDX)      reg_rdata = {24'h0, idx_q};
    else if (reg_addr == OFS_WIN) reg_rdata = win_data;
    else                          reg_rdata = 32'h0;
  end

  // R2: a write through the window to a reserved slot leaves the id register alone.
  p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && !in_table && idx_q != 8'h00) |=> $stable(id_q));

endmodule

// File: rtl/irc_line.sv
module irc_line
  import irc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     irq_raw,
  input  rte_cfg_t cfg,
  input  logic     eoi_valid,
  input  logic [7:0] eoi_vec,
  input  logic     accept,
  output logic     pend,
  output logic     rirr
);
  logic act, prev_q, enabled, edge_ev, lvl_ev, eoi_hit;
  logic unused_fields;

  assign unused_fields = ^{cfg.dest, cfg.edest, cfg.dstmode, cfg.dmode};

  assign act     = irq_raw ^ cfg.pol;
  assign enabled = !cfg.mask && vec_ok(cfg.vec);
  assign edge_ev = !cfg.trig && act && !prev_q;
  assign lvl_ev  = cfg.trig && act && !rirr;
  assign eoi_hit = eoi_valid && cfg.trig && (eoi_vec == cfg.vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
      rirr   <= 1'b0;
    end else begin
      prev_q <= act;
      if (!enabled)    pend <= 1'b0;
      else if (accept) pend <= edge_ev;
      else             pend <= pend | edge_ev | lvl_ev;

      if (!cfg.trig)            rirr <= 1'b0;
      else if (accept)          rirr <= 1'b1;
      else if (eoi_hit)         rirr <= 1'b0;
    end
  end

  // R8: masking a line removes anything it had pending by the next cycle.
  p_mask_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mask |=> !pend);

  // R6: remote IRR only rises as a consequence of an accepted message.
  p_rirr_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr) |-> $past(accept));

endmodule

// File: rtl/irc_arb.sv
module irc_arb
  import irc_pkg::*;
#(
  parameter int NLINE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] pend,
  input  rte_cfg_t         cfg [NLINE],
  input  logic             msi_ready,
  output logic             msi_valid,
  output logic [31:0]      msi_addr,
  output logic [31:0]      msi_data,
  output logic [NLINE-1:0] accept
);
  localparam int IW = (NLINE > 1) ? $clog2(NLINE) : 1;

  logic [IW-1:0] ptr_q, cur_q, win;
  logic          busy_q, found, fire;
  logic [NLINE-1:0] unused_cfg;

  for (genvar g = 0; g < NLINE; g++) begin : g_unused
    assign unused_cfg[g] = ^{cfg[g].mask, cfg[g].pol, cfg[g].dstmode};
  end

  // Round-robin search starting at ptr_q.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < NLINE; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= NLINE) j = j - NLINE;
      if (!found && pend[j]) begin
        found = 1'b1;
        win   = IW'(j);
      end
    end
  end

  assign fire      = busy_q && msi_ready;
  assign msi_valid = busy_q;

  for (genvar g = 0; g < NLINE; g++) begin : g_acc
    assign accept[g] = fire && (cur_q == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cur_q    <= '0;
      busy_q   <= 1'b0;
      msi_addr <= 32'h0;
      msi_data <= 32'h0;
    end else if (fire) begin
      busy_q <= 1'b0;
      ptr_q  <= (int'(cur_q) == NLINE - 1) ? '0 : cur_q + 1'b1;
    end else if (!busy_q && found) begin
      busy_q   <= 1'b1;
      cur_q    <= win;
      msi_addr <= msi_addr_of(cfg[win]);
      msi_data <= msi_data_of(cfg[win]);
    end
  end

  // R11: a presented message is held steady until taken.
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

  // R11: acceptance leaves a gap cycle.
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready) |=> !msi_valid);

  // R10: an idle channel picks up any pending line on the next cycle.
  p_serve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_valid && (|pend)) |=> msi_valid);

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irc_pkg::*;
#(
  parameter int NLINE = 24,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] irq_in,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             msi_valid,
  input  logic             msi_ready,
  output logic [31:0]      msi_addr,
  output logic [31:0]      msi_data
);
  rte_cfg_t         cfg [NLINE];
  logic [NLINE-1:0] pend, rirr, accept;
  logic             eoi_valid;
  logic [7:0]       eoi_vec;

  irc_regs #(.NLINE(NLINE), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_sts  (pend),
    .line_rirr (rirr),
    .cfg       (cfg),
    .eoi_valid (eoi_valid),
    .eoi_vec   (eoi_vec)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    irc_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_raw   (irq_in[g]),
      .cfg       (cfg[g]),
      .eoi_valid (eoi_valid),
      .eoi_vec   (eoi_vec),
      .accept    (accept[g]),
      .pend      (pend[g]),
      .rirr      (rirr[g])
    );
  end

  irc_arb #(.NLINE(NLINE)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .cfg       (cfg),
    .msi_ready (msi_ready),
    .msi_valid (msi_valid),
    .msi_addr  (msi_addr),
    .msi_data  (msi_data),
    .accept    (accept)
  );

endmodule

// File: tb/irq_redir_ctrl_bench.sv
`timescale 1ns/1ps
module irq_redir_ctrl_bench;
  localparam int NLINE = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NLINE-1:0] irq_in = '0;
  logic             reg_valid = 1'b0, reg_write = 1'b0;
  logic [6:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             msi_valid, msi_ready = 1'b1;
  logic [31:0]      msi_addr, msi_data;

  int nchk = 0, nbad = 0;
  bit done = 1'b0;
  logic [63:0] expq [$];

  always #2.5 clk = ~clk;

  irq_redir_ctrl #(.NLINE(NLINE), .AW(7)) u_irq_redir_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // Expected message per R4.
  function automatic logic [63:0] exp_msg(logic [7:0] dest, logic [7:0] edest,
                                          logic trig, logic [2:0] dmode, logic [7:0] vec);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | (32'(dest) << 12) | (32'(edest) << 4);
    d = (32'(trig) << 15) | (32'(dmode) << 8) | 32'(vec);
    return {a, d};
  endfunction

  // Low-half encoding per R3.
  function automatic logic [31:0] mk_lo(logic [7:0] vec, logic [2:0] dmode, logic trig,
                                        logic pol, logic mask);
    return (32'(mask) << 16) | (32'(trig) << 15) | (32'(pol) << 13) |
           (32'(dmode) << 8) | 32'(vec);
  endfunction

  // Scoreboard monitor: compares each accepted message against the queue (R4).
  always @(negedge clk) begin
    if (rst_n && msi_valid && msi_ready) begin
      if (expq.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R8/R12 unexpected message actual=%h_%h expected=none", msi_addr, msi_data);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk("R4 msi_addr", msi_addr, e[63:32]);
        chk("R4 msi_data", msi_data, e[31:0]);
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic wslot(input logic [7:0] s, input logic [31:0] d);
    wr(7'h00, {24'h0, s});
    wr(7'h10, d);
  endtask

  task automatic rslot(input logic [7:0] s, output logic [31:0] d);
    wr(7'h00, {24'h0, s});
    rd(7'h10, d);
  endtask

  task automatic prog(input int n, input logic [7:0] vec, input logic [2:0] dmode,
                      input logic trig, input logic pol, input logic mask,
                      input logic [7:0] dest, input logic [7:0] edest);
    wslot(8'(16 + 2 * n + 1), {dest, edest, 16'h0});
    wslot(8'(16 + 2 * n), mk_lo(vec, dmode, trig, pol, mask));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, a1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    chk("R1 msi_valid", {31'h0, msi_valid}, 32'h0);
    rd(7'h00, v); chk("R1 selector", v, 32'h0);
    rd(7'h10, v); chk("R1 window", v, 32'h0);
    rd(7'h40, v); chk("R1 eoi reads zero", v, 32'h0);
    rslot(8'h10, v); chk("R1 entry0 low", v, 32'h0001_0000);
    rslot(8'h3E, v); chk("R1 entry23 low", v, 32'h0001_0000);

    // R2: id, version, reserved slots
    wslot(8'h00, 32'h1234_5678); rd(7'h10, v); chk("R2 id writable byte", v, 32'h1200_0000);
    wslot(8'h01, 32'hFFFF_FFFF); rd(7'h10, v); chk("R2 version read-only", v, 32'h0017_0020);
    wslot(8'h05, 32'hFFFF_FFFF); rd(7'h10, v); chk("R2 reserved 05", v, 32'h0);
    wslot(8'h40, 32'hFFFF_FFFF); rd(7'h10, v); chk("R2 reserved 40", v, 32'h0);
    rd(7'h00, v); chk("R2 selector readback", v, 32'h40);
    rslot(8'h00, v); chk("R2 id unchanged by reserved writes", v, 32'h1200_0000);

    // R3: field layout, read-only status and remote IRR bits
    wslot(8'h18, 32'h0001_FD32); rd(7'h10, v); chk("R3 entry4 low", v, 32'h0001_AD32);
    wslot(8'h3F, 32'hCAFE_1234); rd(7'h10, v); chk("R3 entry23 high", v, 32'hCAFE_0000);

    // R5/R9/R11: edge line 3, held by a stalled sink
    msi_ready = 1'b0;
    prog(3, 8'h41, 3'd0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h00);
    irq_in[3] = 1'b1;
    expq.push_back(exp_msg(8'h05, 8'h00, 1'b0, 3'd0, 8'h41));
    cyc(3);
    chk("R11 valid while stalled", {31'h0, msi_valid}, 32'h1);
    @(negedge clk); a1 = msi_addr;
    @(negedge clk); chk("R11 addr held", msi_addr, a1);
    rslot(8'h16, v); chk("R9 status while pending", v, 32'h0000_1041);
    @(posedge clk); #1; msi_ready = 1'b1;
    cyc(12);
    rslot(8'h16, v); chk("R9 status after accept", v, 32'h0000_0041);
    irq_in[3] = 1'b0;
    cyc(4);

    // R5: active-low line 5
    irq_in[5] = 1'b1;
    prog(5, 8'h55, 3'd1, 1'b0, 1'b1, 1'b0, 8'h03, 8'h09);
    cyc(8);
    irq_in[5] = 1'b0;
    expq.push_back(exp_msg(8'h03, 8'h09, 1'b0, 3'd1, 8'h55));
    cyc(8);
    irq_in[5] = 1'b1;
    cyc(8);
    chk("R5 one message per edge", 32'(expq.size()), 32'h0);

    // R6/R7: level line 7
    prog(7, 8'h62, 3'd0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h02);
    irq_in[7] = 1'b1;
    expq.push_back(exp_msg(8'h01, 8'h02, 1'b1, 3'd0, 8'h62));
    cyc(20);
    rslot(8'h1E, v); chk("R6 remote IRR set", v, 32'h0000_C062);
    wr(7'h40, 32'h63);
    cyc(10);
    rslot(8'h1E, v); chk("R7 wrong vector keeps IRR", v, 32'h0000_C062);
    wr(7'h40, 32'h62);
    expq.push_back(exp_msg(8'h01, 8'h02, 1'b1, 3'd0, 8'h62));
    cyc(20);
    rslot(8'h1E, v); chk("R7 refire sets IRR again", v, 32'h0000_C062);
    irq_in[7] = 1'b0;
    wr(7'h40, 32'h62);
    cyc(4);
    rslot(8'h1E, v); chk("R7 IRR cleared", v, 32'h0000_8062);
    chk("R6 no extra level messages", 32'(expq.size()), 32'h0);

    // R8: masked edge is dropped
    prog(9, 8'h77, 3'd2, 1'b0, 1'b0, 1'b1, 8'h0A, 8'h0B);
    irq_in[9] = 1'b1;
    cyc(6);
    wslot(8'h22, mk_lo(8'h77, 3'd2, 1'b0, 1'b0, 1'b0));
    cyc(10);
    chk("R8 masked edge dropped", {31'h0, msi_valid}, 32'h0);
    irq_in[9] = 1'b0;
    cyc(2);
    irq_in[9] = 1'b1;
    expq.push_back(exp_msg(8'h0A, 8'h0B, 1'b0, 3'd2, 8'h77));
    cyc(10);

    // R12: out-of-range vector
    prog(10, 8'h05, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01, 8'h01);
    irq_in[10] = 1'b1;
    cyc(10);
    rslot(8'h24, v); chk("R12 invalid vector never pending", v, 32'h0000_0005);
    irq_in[10] = 1'b0;

    // R10: round robin from line 10 (last served was 9): order 12, 20, 2
    msi_ready = 1'b0;
    prog(2,  8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 8'h22, 8'h00);
    prog(12, 8'h2C, 3'd0, 1'b0, 1'b0, 1'b0, 8'h2C, 8'h00);
    prog(20, 8'h34, 3'd0, 1'b0, 1'b0, 1'b0, 8'h34, 8'h00);
    irq_in[2] = 1'b1; irq_in[12] = 1'b1; irq_in[20] = 1'b1;
    expq.push_back(exp_msg(8'h2C, 8'h00, 1'b0, 3'd0, 8'h2C));
    expq.push_back(exp_msg(8'h34, 8'h00, 1'b0, 3'd0, 8'h34));
    expq.push_back(exp_msg(8'h22, 8'h00, 1'b0, 3'd0, 8'h22));
    cyc(4);
    chk("R10 first pick address", msi_addr, 32'hFEE2_C000);
    rslot(8'h14, v); chk("R9 line2 waiting status", v, 32'h0000_1022);
    @(posedge clk); #1; msi_ready = 1'b1;
    cyc(20);
    rslot(8'h14, v); chk("R9 line2 served status", v, 32'h0000_0022);
    chk("R10 all messages delivered", 32'(expq.size()), 32'h0);

    cyc(5);
    finish_run();
  end

endmodule